// File: doc/BRIEF.md
# Hashed Page Table Entry Inserter

The inserter places new translations into an in-memory hashed page table. A configuration word sets where the table lives and how many hash bits select a group. The block checks each configuration write and refuses a value that does not describe a legal table. After that, an insert request names an effective address, a physical address and the virtual segment ID of the segment that the effective address falls in. The segment lookup is done outside the block.

For each request the block hashes the segment ID with the page index and forms the address of a 64-byte group of eight 8-byte entries. It then reads the first word of each slot in ascending order until it finds one whose valid bit is clear. If every slot in that group is taken, it repeats the scan in the group picked by the complemented hash and marks the new entry as a secondary one. The two-word entry is written through a word-wide memory port that waits for an acknowledge on every access. The result is a one-cycle done pulse with an ok flag. When both groups are full, no existing entry is evicted and the request fails.

Top module: `pte_inserter`

## Requirements
- R1: A configuration write is accepted when its mask field `cfg_data_i[15:0]` equals 2^n-1 with 0 <= n <= 9 and its origin field `cfg_data_i[31:16]` has no bit set in common with that mask. After acceptance `cfg_err_o` is low from the next cycle and later inserts use the new table.
- R2: Any other configuration value is rejected. `cfg_err_o` is high from the next cycle, and the table base and hash mask in force before the write are kept.
- R3: After reset the table base is 0 and the mask run is empty (hash mask 0x3FF). `cfg_err_o`, `busy_o`, `done_o` and `mem_req_o` are low.
- R4: The primary hash is the 24-bit segment ID XOR the page index `ea_i[27:12]`. The group address is ((hash AND hash mask) << 6) OR (origin << 16), where the hash mask is (mask << 10) OR 0x3FF.
- R5: Slots are read at group + 8*k for k = 0..7 in ascending order. The first slot whose word 0 has bit 31 clear is taken, whatever its other bits hold. Word 0 is written at the slot address and word 1 at the slot address + 4.
- R6: Word 0 of a new entry is bit 31 set, OR segment ID << 7, OR the hash-select bit at bit 6, OR `ea_i[27:22]` in bits 5:0.
- R7: Word 1 of a new entry is `pa_i` with bits 11:0 cleared.
- R8: If all eight primary slots are valid, the scan repeats from slot 0 of the group given by the bitwise complement of the primary hash, and the entry written there has bit 6 of word 0 set.
- R9: If all sixteen slots are valid, the request ends with `done_o` high and `ok_o` low after sixteen reads and no write.
- R10: Each access holds `mem_req_o`, address, direction and write data until `mem_ack_i`. `done_o` is a one-cycle pulse and `ok_o` is only high with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_data_i | input | 32 | Configuration value: origin [31:16], mask [15:0] |
| cfg_err_o | output | 1 | Last configuration write was rejected |
| req_i | input | 1 | Start an insert (sampled while idle) |
| vsid_i | input | 24 | Virtual segment ID for the request |
| ea_i | input | 32 | Effective address |
| pa_i | input | 32 | Physical address |
| busy_o | output | 1 | Insert in progress |
| done_o | output | 1 | One-cycle completion pulse |
| ok_o | output | 1 | Insert succeeded, valid with done_o |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | 32 | Byte address of the word |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Access complete |

## Verification
`cfg_err_o` settles one cycle after the configuration strobe edge, and the bench samples it at the following falling edge. The bench memory acknowledges one cycle after it sees a request, so every access costs two clock edges. `done_o` is then due exactly 2*(reads + 2) edges after the request edge on success, or 32 edges on failure. The bench counts edges from the request to the done pulse and compares that count with the figure derived from the slot it expects the block to take. It also checks that `done_o` is low one cycle later, and reads the words in its memory model to confirm the entry contents and address.

// File: rtl/pte_ins_pkg.sv
package pte_ins_pkg;
  localparam int unsigned ADDR_W    = 32;
  localparam int unsigned VSID_W    = 24;
  localparam int unsigned PIDX_W    = 16;
  localparam int unsigned API_W     = 6;
  localparam int unsigned FIELD_W   = 16;
  localparam int unsigned RUN_MAX   = 9;
  localparam int unsigned HASH_LOW  = 10;
  localparam int unsigned HASH_W    = RUN_MAX + HASH_LOW;
  localparam int unsigned SLOTS     = 8;
  localparam int unsigned ENTRY_B   = 8;
  localparam int unsigned GRP_SHIFT = 6;
  localparam int unsigned PG_SHIFT  = 12;
  localparam int unsigned VALID_BIT = 31;
  localparam int unsigned HSEL_BIT  = 6;
  localparam int unsigned VSID_SH   = 7;
  localparam int unsigned SLOT_W    = $clog2(SLOTS);
  localparam int unsigned ENTRY_SH  = $clog2(ENTRY_B);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WR_HI,
    ST_WR_LO,
    ST_DONE
  } ins_state_e;
endpackage

// File: rtl/pte_cfg.sv
module pte_cfg
  import pte_ins_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   data_i,
  output logic [ADDR_W-1:0]   base_o,
  output logic [HASH_W-1:0]   hmask_o,
  output logic                err_o
);
  logic [FIELD_W-1:0] mask_f, org_f, mask_inc;
  logic               legal;
  logic [FIELD_W-1:0] org_q;
  logic [RUN_MAX-1:0] run_q;
  logic               err_q;

  assign mask_f   = data_i[FIELD_W-1:0];
  assign org_f    = data_i[ADDR_W-1 -: FIELD_W];
  assign mask_inc = mask_f + FIELD_W'(1);
  // run of ones from bit 0, no longer than RUN_MAX, no overlap with origin
  assign legal = ((mask_f & mask_inc) == '0) &&
                 (mask_f[FIELD_W-1:RUN_MAX] == '0) &&
                 ((org_f & mask_f) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      org_q <= '0;
      run_q <= '0;
      err_q <= 1'b0;
    end else if (we_i) begin
      err_q <= !legal;
      if (legal) begin
        org_q <= org_f;
        run_q <= mask_f[RUN_MAX-1:0];
      end
    end
  end

  assign base_o  = {org_q, {(ADDR_W-FIELD_W){1'b0}}};
  assign hmask_o = {run_q, {HASH_LOW{1'b1}}};
  assign err_o   = err_q;

  // R1
  cfg_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && legal |=> !err_o && base_o[ADDR_W-1 -: FIELD_W] == $past(org_f));
  // R2
  cfg_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !legal |=> err_o && $stable(base_o) && $stable(hmask_o));
endmodule

// File: rtl/pte_hash.sv
module pte_hash
  import pte_ins_pkg::*;
(
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [PIDX_W-1:0] pidx_i,
  input  logic              sec_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [HASH_W-1:0] hmask_i,
  output logic [ADDR_W-1:0] grp_o
);
  logic [VSID_W-1:0] h_pri, h_sel;
  logic [HASH_W-1:0] h_msk;

  assign h_pri = vsid_i ^ {{(VSID_W-PIDX_W){1'b0}}, pidx_i};
  assign h_sel = sec_i ? ~h_pri : h_pri;
  assign h_msk = h_sel[HASH_W-1:0] & hmask_i;
  assign grp_o = base_i | (ADDR_W'(h_msk) << GRP_SHIFT);
endmodule

// File: rtl/pte_inserter.sv
module pte_inserter
  import pte_ins_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [31:0]       cfg_data_i,
  output logic              cfg_err_o,
  input  logic              req_i,
  input  logic [23:0]       vsid_i,
  input  logic [31:0]       ea_i,
  input  logic [31:0]       pa_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              ok_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i
);
  logic [ADDR_W-1:0]          base;
  logic [HASH_W-1:0]          hmask;
  logic [ADDR_W-1:0]          grp, slot_addr;
  ins_state_e                 state_q;
  logic [VSID_W-1:0]          vsid_q;
  logic [PIDX_W-1:0]          pidx_q;
  logic [ADDR_W-PG_SHIFT-1:0] ppn_q;
  logic [SLOT_W-1:0]          slot_q;
  logic                       sec_q, ok_q;
  logic [ADDR_W-1:0]          word0, word1;
  logic                       unused_bits;

  assign unused_bits = ^{ea_i[ADDR_W-1:PG_SHIFT+PIDX_W], ea_i[PG_SHIFT-1:0], pa_i[PG_SHIFT-1:0]};

  pte_cfg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .data_i (cfg_data_i),
    .base_o (base),
    .hmask_o(hmask),
    .err_o  (cfg_err_o)
  );

  pte_hash u_hash (
    .vsid_i (vsid_q),
    .pidx_i (pidx_q),
    .sec_i  (sec_q),
    .base_i (base),
    .hmask_i(hmask),
    .grp_o  (grp)
  );

  assign slot_addr = grp + (ADDR_W'(slot_q) << ENTRY_SH);

  always_comb begin
    word0                          = '0;
    word0[VALID_BIT]               = 1'b1;
    word0[VSID_SH +: VSID_W]       = vsid_q;
    word0[HSEL_BIT]                = sec_q;
    word0[API_W-1:0]               = pidx_q[PIDX_W-1 -: API_W];
    word1                          = {ppn_q, {PG_SHIFT{1'b0}}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vsid_q  <= '0;
      pidx_q  <= '0;
      ppn_q   <= '0;
      slot_q  <= '0;
      sec_q   <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          vsid_q  <= vsid_i;
          pidx_q  <= ea_i[PG_SHIFT +: PIDX_W];
          ppn_q   <= pa_i[ADDR_W-1:PG_SHIFT];
          slot_q  <= '0;
          sec_q   <= 1'b0;
          ok_q    <= 1'b0;
          state_q <= ST_READ;
        end
        ST_READ: if (mem_ack_i) begin
          if (!mem_rdata_i[VALID_BIT]) begin
            state_q <= ST_WR_HI;
          end else if (slot_q == SLOT_W'(SLOTS-1)) begin
            slot_q <= '0;
            if (sec_q) state_q <= ST_DONE;
            else       sec_q   <= 1'b1;
          end else begin
            slot_q <= slot_q + SLOT_W'(1);
          end
        end
        ST_WR_HI: if (mem_ack_i) state_q <= ST_WR_LO;
        ST_WR_LO: if (mem_ack_i) begin
          ok_q    <= 1'b1;
          state_q <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_DONE);
  assign ok_o        = done_o && ok_q;
  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WR_HI) || (state_q == ST_WR_LO);
  assign mem_we_o    = (state_q == ST_WR_HI) || (state_q == ST_WR_LO);
  assign mem_addr_o  = (state_q == ST_WR_LO) ? slot_addr + ADDR_W'(ENTRY_B/2) : slot_addr;
  assign mem_wdata_o = (state_q == ST_WR_LO) ? word1 : word0;

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  ok_with_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> done_o);
  // R5
  second_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_WR_HI && mem_ack_i |=> mem_addr_o == $past(mem_addr_o) + ADDR_W'(ENTRY_B/2));
  // R9
  full_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_READ && mem_ack_i && mem_rdata_i[VALID_BIT] && sec_q && slot_q == SLOT_W'(SLOTS-1)
    |=> done_o && !ok_o);
endmodule

// File: tb/pte_inserter_tb_top.sv
module pte_inserter_tb_top;
  typedef struct packed {
    logic [31:0] cfg;
    logic [31:0] vsid;
    logic [31:0] ea;
    logic [31:0] pa;
    logic [3:0]  fp;
    logic [3:0]  fs;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 32'h0000_1234, 32'h0ABC_D000, 32'h1234_5000, 4'd0, 4'd0},
    '{32'h0010_000F, 32'h00AB_CDEF, 32'h3FFF_F000, 32'hFEDC_B000, 4'd3, 4'd0},
    '{32'h0200_01FF, 32'h000F_0F0F, 32'h5555_5000, 32'h0000_1000, 4'd7, 4'd0},
    '{32'h0000_0003, 32'h0012_3456, 32'h0000_0000, 32'hAAAA_A000, 4'd8, 4'd0},
    '{32'h0040_003F, 32'h0000_FFFF, 32'hF123_4FFF, 32'h7777_7ABC, 4'd8, 4'd5},
    '{32'h0000_0001, 32'h0000_0001, 32'h1000_0000, 32'h0000_0001, 4'd8, 4'd8}
  };

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we_i = 1'b0;
  logic [31:0] cfg_data_i = '0;
  logic cfg_err_o;
  logic req_i = 1'b0;
  logic [23:0] vsid_i = '0;
  logic [31:0] ea_i = '0, pa_i = '0;
  logic busy_o, done_o, ok_o, mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic [31:0] mem_rdata_i = '0;
  logic mem_ack_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int wr_cnt = 0;
  logic [31:0] mem [logic [31:0]];

  always #5 clk_i = ~clk_i;

  pte_inserter dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_we_i(cfg_we_i), .cfg_data_i(cfg_data_i),
    .cfg_err_o(cfg_err_o), .req_i(req_i), .vsid_i(vsid_i), .ea_i(ea_i), .pa_i(pa_i),
    .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i), .mem_ack_i(mem_ack_i)
  );

  // memory model: acknowledge one cycle after a request is seen
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      mem_ack_i <= 1'b0;
    end else begin
      mem_ack_i <= mem_req_o && !mem_ack_i;
      if (mem_req_o && !mem_ack_i) begin
        if (mem_we_o) begin
          mem[mem_addr_o] = mem_wdata_o;
          wr_cnt++;
        end
        mem_rdata_i <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 32'h0;
      end
    end
  end

  task automatic chk(input bit c, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] grp_model(input logic [31:0] cfg, input logic [23:0] vsid,
                                            input logic [31:0] ea, input bit sec);
    logic [23:0] h;
    logic [18:0] hm;
    h  = vsid ^ {8'h0, ea[27:12]};
    if (sec) h = ~h;
    hm = {cfg[8:0], 10'h3FF};
    return {cfg[31:16], 16'h0} | (32'(h[18:0] & hm) << 6);
  endfunction

  function automatic logic [31:0] w0_model(input logic [23:0] vsid, input logic [31:0] ea, input bit sec);
    return 32'h8000_0000 | (32'(vsid) << 7) | (32'(sec) << 6) | 32'(ea[27:22]);
  endfunction

  task automatic cfg_write(input logic [31:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1;
    cfg_data_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  task automatic do_insert(input logic [23:0] vsid, input logic [31:0] ea, input logic [31:0] pa,
                           output int lat, output bit ok);
    @(negedge clk_i);
    req_i = 1'b1; vsid_i = vsid; ea_i = ea; pa_i = pa;
    @(posedge clk_i);
    lat = 0;
    ok = 1'b0;
    forever begin
      @(negedge clk_i);
      req_i = 1'b0;
      if (done_o) begin
        ok = ok_o;
        break;
      end
      if (lat > 200) break;
      @(posedge clk_i);
      lat++;
    end
    @(negedge clk_i);
    chk(!done_o, "R10 done one cycle", 32'(done_o), 32'h0);
  endtask

  task automatic fill(input logic [31:0] g, input int n);
    for (int k = 0; k < 8; k++)
      mem[g + 32'(8*k)] = (k < n) ? 32'h8000_0000 : 32'h7FFF_FFFF;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    bit ok;
    logic [31:0] a;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R3 reset state
    chk(!cfg_err_o, "R3 cfg_err", 32'(cfg_err_o), 0);
    chk(!busy_o && !done_o, "R3 idle", {30'h0, busy_o, done_o}, 0);
    chk(!mem_req_o, "R3 mem_req", 32'(mem_req_o), 0);
    // R3 reset table settings in force before any write
    mem.delete(); wr_cnt = 0;
    do_insert(24'h000ABC, 32'h0123_4000, 32'h0000_5000, lat, ok);
    a = grp_model(32'h0, 24'h000ABC, 32'h0123_4000, 1'b0);
    chk(ok, "R3 insert ok", 32'(ok), 1);
    chk(mem.exists(a) && mem[a] == w0_model(24'h000ABC, 32'h0123_4000, 1'b0),
        "R3 reset table address", a, w0_model(24'h000ABC, 32'h0123_4000, 1'b0));

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] gp, gs, exp_a;
      bit exp_ok, exp_sec;
      int reads;
      v = VECS[i];
      cfg_write(v.cfg);
      chk(!cfg_err_o, "R1 accepted", 32'(cfg_err_o), 0);
      mem.delete();
      gp = grp_model(v.cfg, v.vsid[23:0], v.ea, 1'b0);
      gs = grp_model(v.cfg, v.vsid[23:0], v.ea, 1'b1);
      fill(gp, int'(v.fp));
      fill(gs, int'(v.fs));
      wr_cnt = 0;
      exp_sec = (v.fp == 4'd8);
      exp_ok  = !(exp_sec && v.fs == 4'd8);
      exp_a   = exp_sec ? gs + 32'(8*int'(v.fs)) : gp + 32'(8*int'(v.fp));
      reads   = exp_sec ? (exp_ok ? 9 + int'(v.fs) : 16) : 1 + int'(v.fp);
      do_insert(v.vsid[23:0], v.ea, v.pa, lat, ok);
      chk(ok == exp_ok, exp_ok ? "R5 ok flag" : "R9 fail flag", 32'(ok), 32'(exp_ok));
      chk(lat == (exp_ok ? 2*(reads+2) : 2*reads), "R10 latency", lat,
          exp_ok ? 2*(reads+2) : 2*reads);
      if (exp_ok) begin
        logic [31:0] w0e;
        w0e = w0_model(v.vsid[23:0], v.ea, exp_sec);
        chk(mem[exp_a] == w0e, exp_sec ? "R8 secondary word0" : "R6 word0 at R4 group slot",
            mem[exp_a], w0e);
        chk(mem[exp_a + 4] == (v.pa & 32'hFFFF_F000), "R7 word1", mem[exp_a + 4],
            v.pa & 32'hFFFF_F000);
        chk(wr_cnt == 2, "R5 two writes", wr_cnt, 2);
      end else begin
        chk(wr_cnt == 0, "R9 no write", wr_cnt, 0);
      end
    end

    // rejected writes keep previous settings
    cfg_write(32'h0010_000F);
    chk(!cfg_err_o, "R1 accepted", 32'(cfg_err_o), 0);
    cfg_write(32'h0000_0005);
    chk(cfg_err_o, "R2 non-contiguous mask", 32'(cfg_err_o), 1);
    cfg_write(32'h0000_03FF);
    chk(cfg_err_o, "R2 mask run too long", 32'(cfg_err_o), 1);
    cfg_write(32'h0001_0001);
    chk(cfg_err_o, "R2 origin overlaps mask", 32'(cfg_err_o), 1);
    mem.delete(); wr_cnt = 0;
    do_insert(24'h055AA5, 32'h7654_3000, 32'h0BAD_0000, lat, ok);
    a = grp_model(32'h0010_000F, 24'h055AA5, 32'h7654_3000, 1'b0);
    chk(mem.exists(a) && mem[a] == w0_model(24'h055AA5, 32'h7654_3000, 1'b0),
        "R2 previous table kept", mem.exists(a) ? mem[a] : 32'h0,
        w0_model(24'h055AA5, 32'h7654_3000, 1'b0));
    cfg_write(32'h0000_0000);
    chk(!cfg_err_o, "R1 error cleared", 32'(cfg_err_o), 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule